// File: doc/BRIEF.md
# Pipelined Four-Value Sorter

This block takes a set of four unsigned values together with a single valid bit and returns the same four values in sorted order, after a fixed number of clock cycles. It accepts a new set on every cycle. It never stalls and has no backpressure, so a producer can stream sets into it back to back. The valid bit travels beside the data, and the consumer sees a matching output valid when the sorted set arrives.

The sorting uses a five-comparator network that is arranged in three comparator levels. Pipeline registers sit between the levels. The `STAGES` parameter (1 to 3) chooses how many register boundaries are used, and that number is also the latency in cycles. The last level always ends in a register. `DESCEND` picks the output order, and `WIDTH` sets the value width.

Top module: `sort4_pipe`

## Requirements
- R1: Each valid output set is a permutation of the input set it came from, with every value treated as a `WIDTH`-bit unsigned number.
- R2: With `DESCEND` = 0, `outData0` holds the smallest value and the outputs do not decrease from index 0 to index 3. For example, inputs (`inData0`..`inData3`) = 04,03,02,01 give 01,02,03,04.
- R3: With `DESCEND` = 1, `outData0` holds the largest value and the outputs do not increase from index 0 to index 3. For example, inputs 04,08,00,09 give 09,08,04,00.
- R4: Sets that contain repeated values are still sorted correctly, and equal values appear next to each other in the output.
- R5: `outValid` in cycle N+`STAGES` equals `inValid` in cycle N. With the default `STAGES` = 2, a set presented in cycle N appears in cycle N+2.
- R6: Sets presented on consecutive cycles come out on consecutive cycles, in the order they went in, with no bubble between them.
- R7: While `rst` is high, and after it falls until the first valid set has crossed the pipeline, `outValid` stays 0 whatever `inValid` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is sampled on the rising edge |
| rst | input | 1 | Synchronous reset, active high; clears every stage valid bit |
| inValid | input | 1 | Marks the four input values as a set to sort |
| inData0 | input | WIDTH | Input value, position 0 |
| inData1 | input | WIDTH | Input value, position 1 |
| inData2 | input | WIDTH | Input value, position 2 |
| inData3 | input | WIDTH | Input value, position 3 |
| outValid | output | 1 | Marks the output values as a sorted set |
| outData0 | output | WIDTH | Sorted value, first position (smallest or largest) |
| outData1 | output | WIDTH | Sorted value, position 1 |
| outData2 | output | WIDTH | Sorted value, position 2 |
| outData3 | output | WIDTH | Sorted value, last position |

## Verification
In the same cycle, the block takes in a new set at the head of the pipe and delivers an older set at the tail. Each stage can also be loading one set while the next stage still holds the set ahead of it. The bench provokes this with runs of back-to-back valid sets, with isolated sets between gaps, and with both kinds mixed at random. It feeds the same stimulus to an ascending two-stage instance and to a descending three-stage instance. Each output cycle is judged against the set presented exactly `STAGES` cycles earlier and sorted by a bench function. A set that leaks into its neighbour, or is lost by it, therefore shows up as a wrong value or a wrong valid in that cycle.

// File: rtl/sort4_pkg.sv
package sort4_pkg;

  // Load strobes from control to datapath, one per register boundary
  typedef struct packed {
    logic [2:0] load;
  } sortStrobe_t;

  // Boundary k follows comparator level k; the last one is always a register
  function automatic bit stageRegAt(int stages, int k);
    return (k == 2) || (stages >= 3) || (stages == 2 && k == 0);
  endfunction

endpackage

// File: rtl/sort4_cas.sv
module sort4_cas #(
  parameter int WIDTH   = 8,
  parameter bit DESCEND = 1'b0
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] first,
  output logic [WIDTH-1:0] second
);
  logic keepOrder;

  always_comb begin
    keepOrder = DESCEND ? (a >= b) : (a <= b);
    first     = keepOrder ? a : b;
    second    = keepOrder ? b : a;
  end
endmodule

// File: rtl/sort4_stage.sv
module sort4_stage #(
  parameter int WIDTH = 8,
  parameter bit REG   = 1'b1
) (
  input  logic                 clk,
  input  logic                 load,
  input  logic [3:0][WIDTH-1:0] d,
  output logic [3:0][WIDTH-1:0] q
);
  generate
    if (REG) begin : g_reg
      logic [3:0][WIDTH-1:0] held;
      always_ff @(posedge clk) begin
        if (load) held <= d;
      end
      assign q = held;
    end else begin : g_wire
      logic unusedLoad;
      assign unusedLoad = load;
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/sort4_ctrl.sv
module sort4_ctrl
  import sort4_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output sortStrobe_t strobe,
  output logic        outValid
);
  logic [2:0] vIn;
  logic [2:0] vOut;

  assign vIn[0] = inValid;
  assign vIn[1] = vOut[0];
  assign vIn[2] = vOut[1];

  generate
    for (genvar k = 0; k < 3; k++) begin : g_bnd
      if (stageRegAt(STAGES, k)) begin : g_reg
        logic vHeld;
        always_ff @(posedge clk) begin
          if (rst) vHeld <= 1'b0;
          else     vHeld <= vIn[k];
        end
        assign vOut[k] = vHeld;
      end else begin : g_wire
        assign vOut[k] = vIn[k];
      end
    end
  endgenerate

  assign strobe.load = vIn;
  assign outValid    = vOut[2];
endmodule

// File: rtl/sort4_dpath.sv
module sort4_dpath
  import sort4_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int STAGES  = 2,
  parameter bit DESCEND = 1'b0
) (
  input  logic                  clk,
  input  sortStrobe_t           strobe,
  input  logic [3:0][WIDTH-1:0] inSet,
  output logic [3:0][WIDTH-1:0] outSet
);
  localparam bit REG0 = stageRegAt(STAGES, 0);
  localparam bit REG1 = stageRegAt(STAGES, 1);
  localparam bit REG2 = stageRegAt(STAGES, 2);

  logic [3:0][WIDTH-1:0] lvl1, bnd1, lvl2, bnd2, lvl3;

  // Level 1: pairs (0,1) and (2,3)
  sort4_cas #(.WIDTH(WIDTH), .DESCEND(DESCEND)) u_c01 (
    .a(inSet[0]), .b(inSet[1]), .first(lvl1[0]), .second(lvl1[1]));
  sort4_cas #(.WIDTH(WIDTH), .DESCEND(DESCEND)) u_c23 (
    .a(inSet[2]), .b(inSet[3]), .first(lvl1[2]), .second(lvl1[3]));

  sort4_stage #(.WIDTH(WIDTH), .REG(REG0)) u_b0 (
    .clk(clk), .load(strobe.load[0]), .d(lvl1), .q(bnd1));

  // Level 2: extremes settle at positions 0 and 3
  sort4_cas #(.WIDTH(WIDTH), .DESCEND(DESCEND)) u_c02 (
    .a(bnd1[0]), .b(bnd1[2]), .first(lvl2[0]), .second(lvl2[2]));
  sort4_cas #(.WIDTH(WIDTH), .DESCEND(DESCEND)) u_c13 (
    .a(bnd1[1]), .b(bnd1[3]), .first(lvl2[1]), .second(lvl2[3]));

  sort4_stage #(.WIDTH(WIDTH), .REG(REG1)) u_b1 (
    .clk(clk), .load(strobe.load[1]), .d(lvl2), .q(bnd2));

  // Level 3: middle pair
  assign lvl3[0] = bnd2[0];
  assign lvl3[3] = bnd2[3];
  sort4_cas #(.WIDTH(WIDTH), .DESCEND(DESCEND)) u_c12 (
    .a(bnd2[1]), .b(bnd2[2]), .first(lvl3[1]), .second(lvl3[2]));

  sort4_stage #(.WIDTH(WIDTH), .REG(REG2)) u_b2 (
    .clk(clk), .load(strobe.load[2]), .d(lvl3), .q(outSet));
endmodule

// File: rtl/sort4_pipe.sv
module sort4_pipe
  import sort4_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int STAGES  = 2,
  parameter bit DESCEND = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [WIDTH-1:0] inData0,
  input  logic [WIDTH-1:0] inData1,
  input  logic [WIDTH-1:0] inData2,
  input  logic [WIDTH-1:0] inData3,
  output logic             outValid,
  output logic [WIDTH-1:0] outData0,
  output logic [WIDTH-1:0] outData1,
  output logic [WIDTH-1:0] outData2,
  output logic [WIDTH-1:0] outData3
);
  sortStrobe_t           strobe;
  logic [3:0][WIDTH-1:0] inSet;
  logic [3:0][WIDTH-1:0] outSet;

  assign inSet = {inData3, inData2, inData1, inData0};

  sort4_ctrl #(.STAGES(STAGES)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .strobe(strobe), .outValid(outValid));

  sort4_dpath #(.WIDTH(WIDTH), .STAGES(STAGES), .DESCEND(DESCEND)) u_dpath (
    .clk(clk), .strobe(strobe), .inSet(inSet), .outSet(outSet));

  assign outData0 = outSet[0];
  assign outData1 = outSet[1];
  assign outData2 = outSet[2];
  assign outData3 = outSet[3];
endmodule

// File: rtl/sort4_chk.sv
module sort4_chk #(
  parameter int WIDTH   = 8,
  parameter int STAGES  = 2,
  parameter bit DESCEND = 1'b0
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic [WIDTH-1:0] inData0,
  input logic [WIDTH-1:0] inData1,
  input logic [WIDTH-1:0] inData2,
  input logic [WIDTH-1:0] inData3,
  input logic             outValid,
  input logic [WIDTH-1:0] outData0,
  input logic [WIDTH-1:0] outData1,
  input logic [WIDTH-1:0] outData2,
  input logic [WIDTH-1:0] outData3
);
  logic [2:0]       sinceRst;
  logic [WIDTH+1:0] inSum, outSum;

  always_ff @(posedge clk) begin
    if (rst)                  sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  assign inSum  = (WIDTH+2)'(inData0) + (WIDTH+2)'(inData1) + (WIDTH+2)'(inData2) + (WIDTH+2)'(inData3);
  assign outSum = (WIDTH+2)'(outData0) + (WIDTH+2)'(outData1) + (WIDTH+2)'(outData2) + (WIDTH+2)'(outData3);

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !outValid); // R7

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 3'(STAGES)) |-> (outValid == $past(inValid, STAGES))); // R5

  AST_SUM_KEPT: assert property (@(posedge clk) disable iff (rst)
    (outValid && sinceRst >= 3'(STAGES)) |-> (outSum == $past(inSum, STAGES))); // R1

  generate
    if (DESCEND) begin : g_desc
      AST_ORDER_DESC: assert property (@(posedge clk) disable iff (rst)
        outValid |-> (outData0 >= outData1 && outData1 >= outData2 && outData2 >= outData3)); // R3
    end else begin : g_asc
      AST_ORDER_ASC: assert property (@(posedge clk) disable iff (rst)
        outValid |-> (outData0 <= outData1 && outData1 <= outData2 && outData2 <= outData3)); // R2
    end
  endgenerate
endmodule

bind sort4_pipe sort4_chk #(.WIDTH(WIDTH), .STAGES(STAGES), .DESCEND(DESCEND)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid),
  .inData0(inData0), .inData1(inData1), .inData2(inData2), .inData3(inData3),
  .outValid(outValid),
  .outData0(outData0), .outData1(outData1), .outData2(outData2), .outData3(outData3));

// File: tb/sort4_pipe_bench.sv
module sort4_pipe_bench;
  localparam int W      = 8;
  localparam int NCYC   = 1500;
  localparam int LASC   = 2;
  localparam int LDESC  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [W-1:0] d0 = '0, d1 = '0, d2 = '0, d3 = '0;
  logic aV, bV;
  logic [W-1:0] a0, a1, a2, a3, b0, b1, b2, b3;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [3:0][W-1:0] hData [0:NCYC+15];
  logic              hValid[0:NCYC+15];

  always #4 clk = ~clk;

  sort4_pipe u_sort4_pipe (
    .clk(clk), .rst(rst), .inValid(inValid),
    .inData0(d0), .inData1(d1), .inData2(d2), .inData3(d3),
    .outValid(aV), .outData0(a0), .outData1(a1), .outData2(a2), .outData3(a3));

  sort4_pipe #(.WIDTH(W), .STAGES(LDESC), .DESCEND(1'b1)) u_sort4_pipe_desc (
    .clk(clk), .rst(rst), .inValid(inValid),
    .inData0(d0), .inData1(d1), .inData2(d2), .inData3(d3),
    .outValid(bV), .outData0(b0), .outData1(b1), .outData2(b2), .outData3(b3));

  function automatic logic [3:0][W-1:0] sortSet(logic [3:0][W-1:0] s, bit desc);
    logic [3:0][W-1:0] r = s;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3 - i; j++)
        if (desc ? (r[j] < r[j+1]) : (r[j] > r[j+1])) begin
          logic [W-1:0] tmp = r[j];
          r[j] = r[j+1];
          r[j+1] = tmp;
        end
    return r;
  endfunction

  function automatic bit hasDup(logic [3:0][W-1:0] s);
    return (s[0] == s[1]) || (s[0] == s[2]) || (s[0] == s[3]) ||
           (s[1] == s[2]) || (s[1] == s[3]) || (s[2] == s[3]);
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic checkOne(int t, int lat, bit desc, logic v, logic [3:0][W-1:0] got, string name);
    logic expV;
    logic [3:0][W-1:0] expD;
    string tag;
    expV = (t >= lat) ? hValid[t-lat] : 1'b0;
    if (t < lat)                                      tag = "R7";
    else if (t >= lat + 1 && hValid[t-lat] && hValid[t-lat-1]) tag = "R6";
    else                                              tag = "R5";
    check(v === expV, tag, {name, " valid"}, 32'(v), 32'(expV));
    if (expV) begin
      expD = sortSet(hData[t-lat], desc);
      if (hasDup(hData[t-lat])) tag = "R4";
      else                      tag = desc ? "R1 R3" : "R1 R2";
      check(got === expD, tag, {name, " data"}, got, expD);
    end
  endtask

  function automatic logic [3:0][W-1:0] mk(logic [W-1:0] x0, logic [W-1:0] x1,
                                            logic [W-1:0] x2, logic [W-1:0] x3);
    return {x3, x2, x1, x0};
  endfunction

  task automatic pickSet(int t, output logic v, output logic [3:0][W-1:0] s);
    v = 1'b1;
    case (t)
      0:  s = mk(8'h04, 8'h03, 8'h02, 8'h01);   // R2 example
      1:  s = mk(8'h09, 8'h06, 8'h07, 8'h01);
      2:  s = mk(8'h04, 8'h08, 8'h00, 8'h09);   // R3 example
      3:  begin v = 1'b0; s = mk(8'hAA, 8'h55, 8'h11, 8'h22); end
      4:  s = mk(8'h05, 8'h05, 8'h05, 8'h05);   // R4
      5:  s = mk(8'hFF, 8'h00, 8'hFF, 8'h00);   // R4
      6:  s = mk(8'h00, 8'h00, 8'h00, 8'h00);
      7:  s = mk(8'hFF, 8'hFF, 8'hFF, 8'hFF);
      8:  s = mk(8'h03, 8'h03, 8'h01, 8'h01);
      9:  begin v = 1'b0; s = mk(8'h00, 8'h01, 8'h02, 8'h03); end
      10: begin v = 1'b0; s = mk(8'h07, 8'h07, 8'h07, 8'h07); end
      11: s = mk(8'h01, 8'h02, 8'h03, 8'h04);
      default: begin
        if (t >= NCYC) v = 1'b0;
        else if (t < 100) v = 1'b1;               // R6 long stream
        else v = ($urandom % 4) != 0;
        s = mk(W'($urandom), W'($urandom), W'($urandom), W'($urandom));
        if (($urandom % 8) == 0) s[$urandom % 4] = s[$urandom % 4];
      end
    endcase
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(aV === 1'b0, "R7", "asc valid in reset", 32'(aV), 32'h0);
      check(bV === 1'b0, "R7", "desc valid in reset", 32'(bV), 32'h0);
      inValid = 1'b1;
      d0 = W'($urandom); d1 = W'($urandom); d2 = W'($urandom); d3 = W'($urandom);
    end
    for (int t = 0; t < NCYC + 6; t++) begin
      logic v;
      logic [3:0][W-1:0] s;
      @(negedge clk);
      if (t > 0) begin
        checkOne(t, LASC,  1'b0, aV, {a3, a2, a1, a0}, "asc");
        checkOne(t, LDESC, 1'b1, bV, {b3, b2, b1, b0}, "desc");
      end else begin
        check(aV === 1'b0, "R7", "asc valid at release", 32'(aV), 32'h0);
        check(bV === 1'b0, "R7", "desc valid at release", 32'(bV), 32'h0);
      end
      rst = 1'b0;
      pickSet(t, v, s);
      hValid[t] = v;
      hData[t]  = s;
      inValid = v;
      {d3, d2, d1, d0} = s;
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule